// File: doc/BRIEF.md
# Fetch-Steered Boot Overlay Decoder

This block sits between an 8-bit CPU and three memories: general RAM, a boot ROM and a video RAM. The address space splits into a large lower region that is always RAM and a 4 KiB upper window that the boot ROM and the video RAM share. No software control register chooses which memory a data read of the window sees. The choice comes from the region of the most recent opcode fetch.

A fetch from the window serves ROM bytes and sets the bank flag to ROM. A fetch from the lower region serves RAM bytes and sets the flag to video RAM. Data reads of the window then return the memory that the flag names. Data writes to the window always land in video RAM. The flag resets to ROM, so a CPU that starts at the base of the window can run from ROM. While it does, its data reads of the window also see ROM. Once it jumps into RAM, the same addresses show video memory.

The decode and read mux are combinational. The flag is the only state, and it updates on the clock edge that ends the fetch cycle.

Top module: `overlay_decode_top`

## Requirements
- R1: A read or write with the top four address bits not all ones (0x0000–0xEFFF) selects RAM only (`ram_cs`, with `ram_we` on writes), and a read returns `ram_rdata`.
- R2: An opcode fetch (`cpu_rd` and `cpu_m1` high) with address 0xF000–0xFFFF returns `rom_rdata` in the same cycle, whatever the current flag value.
- R3: After the clock edge that ends a fetch in 0xF000–0xFFFF, `bank_rom` is 1.
- R4: An opcode fetch in 0x0000–0xEFFF returns `ram_rdata`, and after the clock edge that ends it, `bank_rom` is 0.
- R5: A data read (`cpu_m1` low) in 0xF000–0xFFFF returns `rom_rdata` while `bank_rom` is 1 and `vram_rdata` while it is 0.
- R6: A write (`cpu_wr` high) in 0xF000–0xFFFF asserts `vram_cs` and `vram_we` and never `rom_cs`, in either flag state.
- R7: While `rst` is high at a clock edge, `bank_rom` becomes 1.
- R8: At most one of `ram_cs`, `rom_cs` and `vram_cs` is high. With neither strobe active, all three are low and `cpu_rdata` is 0.
- R9: Data reads, writes and idle cycles leave `bank_rom` unchanged.
- R10: `win_offset` carries the low 12 address bits, which index ROM and video RAM inside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe, active high |
| cpu_wr | input | 1 | Write strobe, active high (wins over `cpu_rd`) |
| cpu_m1 | input | 1 | Opcode-fetch indication, active high |
| ram_rdata | input | 8 | Read data from RAM |
| rom_rdata | input | 8 | Read data from boot ROM |
| vram_rdata | input | 8 | Read data from video RAM |
| ram_cs | output | 1 | RAM select |
| ram_we | output | 1 | RAM write enable |
| rom_cs | output | 1 | Boot ROM select |
| vram_cs | output | 1 | Video RAM select |
| vram_we | output | 1 | Video RAM write enable |
| win_offset | output | 12 | Address offset inside the upper window |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| bank_rom | output | 1 | Bank flag: 1 = ROM, 0 = video RAM |

## Verification
The bench fills ROM and video RAM with different patterns so that every read of the window shows which memory served it. A data read of 0xF000 is made after a fetch from the window and again after a fetch from low RAM. The two reads must return different bytes. A fetch from the window while the flag is 0 shows that fetch data follows the address, not the old flag. Writes into the window are made in both flag states. Each is read back after a low fetch, which shows that it reached video RAM without moving the flag. The bench also probes the 0xEFFF/0xF000 boundary and a reset asserted in mid-run.

// File: rtl/overlay_pkg.sv
package overlay_pkg;

    localparam int unsigned DEF_ADDR_W = 16;
    localparam int unsigned DEF_DATA_W = 8;
    localparam int unsigned DEF_WIN_W  = 12;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_FETCH = 2'd1,
        CYC_READ  = 2'd2,
        CYC_WRITE = 2'd3
    } cyc_kind_e;

    typedef struct packed {
        cyc_kind_e kind;
        logic      in_win;
    } cyc_t;

    function automatic cyc_kind_e classify(input logic rd, input logic wr, input logic m1);
        if (wr)
            return CYC_WRITE;
        else if (rd && m1)
            return CYC_FETCH;
        else if (rd)
            return CYC_READ;
        return CYC_IDLE;
    endfunction

endpackage

// File: rtl/overlay_cycle_decode.sv
module overlay_cycle_decode
    import overlay_pkg::*;
#(
    parameter int unsigned HI_W = DEF_ADDR_W - DEF_WIN_W
) (
    input  logic [HI_W-1:0] addr_hi,
    input  logic            rd,
    input  logic            wr,
    input  logic            m1,
    output cyc_t            cyc
);

    always_comb begin
        cyc.kind   = classify(rd, wr, m1);
        cyc.in_win = &addr_hi;
    end

endmodule

// File: rtl/overlay_bank_track.sv
module overlay_bank_track
    import overlay_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cyc_t cyc,
    output logic bank_rom
);

    always_ff @(posedge clk) begin
        if (rst)
            bank_rom <= 1'b1;
        else if (cyc.kind == CYC_FETCH)
            bank_rom <= cyc.in_win;
    end

    // R3: a fetch inside the window leaves the flag at ROM
    assert_win_fetch_sets_rom_R3: assert property (@(posedge clk) disable iff (rst)
        (cyc.kind == CYC_FETCH && cyc.in_win) |=> bank_rom);

    // R4: a fetch below the window leaves the flag at video RAM
    assert_low_fetch_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (cyc.kind == CYC_FETCH && !cyc.in_win) |=> !bank_rom);

    // R9: non-fetch cycles hold the flag
    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (cyc.kind != CYC_FETCH) |=> $stable(bank_rom));

    // R7: reset forces the ROM state
    assert_reset_rom_R7: assert property (@(posedge clk)
        rst |=> bank_rom);

endmodule

// File: rtl/overlay_select.sv
module overlay_select
    import overlay_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  cyc_t              cyc,
    input  logic              bank_rom,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [DATA_W-1:0] vram_rdata,
    output logic              ram_cs,
    output logic              ram_we,
    output logic              rom_cs,
    output logic              vram_cs,
    output logic              vram_we,
    output logic [DATA_W-1:0] cpu_rdata
);

    logic is_rd;
    logic use_rom;

    always_comb begin
        is_rd   = (cyc.kind == CYC_FETCH) || (cyc.kind == CYC_READ);
        // fetches pick by address alone; data reads follow the flag
        use_rom = (cyc.kind == CYC_FETCH) ? 1'b1 : bank_rom;

        ram_cs  = 1'b0;
        ram_we  = 1'b0;
        rom_cs  = 1'b0;
        vram_cs = 1'b0;
        vram_we = 1'b0;

        if (cyc.kind == CYC_WRITE) begin
            if (cyc.in_win) begin
                vram_cs = 1'b1;
                vram_we = 1'b1;
            end else begin
                ram_cs = 1'b1;
                ram_we = 1'b1;
            end
        end else if (is_rd) begin
            if (!cyc.in_win)
                ram_cs = 1'b1;
            else if (use_rom)
                rom_cs = 1'b1;
            else
                vram_cs = 1'b1;
        end
    end

    always_comb begin
        cpu_rdata = '0;
        if (is_rd) begin
            if (ram_cs)
                cpu_rdata = ram_rdata;
            else if (rom_cs)
                cpu_rdata = rom_rdata;
            else if (vram_cs)
                cpu_rdata = vram_rdata;
        end
    end

    // R8: selects are mutually exclusive
    assert_one_select_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ram_cs, rom_cs, vram_cs}));

    // R6: window writes reach video RAM and never the ROM
    assert_win_write_vram_R6: assert property (@(posedge clk) disable iff (rst)
        (cyc.kind == CYC_WRITE && cyc.in_win) |-> (vram_we && !rom_cs));

    // R5: a window data read while the flag is clear goes to video RAM
    assert_data_read_vram_R5: assert property (@(posedge clk) disable iff (rst)
        (cyc.kind == CYC_READ && cyc.in_win && !bank_rom) |-> (vram_cs && cpu_rdata == vram_rdata));

    // R2: a window fetch is served by ROM even when the flag is clear
    assert_fetch_rom_R2: assert property (@(posedge clk) disable iff (rst)
        (cyc.kind == CYC_FETCH && cyc.in_win) |-> (rom_cs && cpu_rdata == rom_rdata));

endmodule

// File: rtl/overlay_decode_top.sv
module overlay_decode_top
    import overlay_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned WIN_W  = DEF_WIN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic              cpu_m1,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [DATA_W-1:0] vram_rdata,
    output logic              ram_cs,
    output logic              ram_we,
    output logic              rom_cs,
    output logic              vram_cs,
    output logic              vram_we,
    output logic [WIN_W-1:0]  win_offset,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bank_rom
);

    localparam int unsigned HI_W = ADDR_W - WIN_W;

    cyc_t cyc;

    assign win_offset = cpu_addr[WIN_W-1:0];

    overlay_cycle_decode #(.HI_W(HI_W)) u_decode (
        .addr_hi (cpu_addr[ADDR_W-1:WIN_W]),
        .rd      (cpu_rd),
        .wr      (cpu_wr),
        .m1      (cpu_m1),
        .cyc     (cyc)
    );

    overlay_bank_track u_bank (
        .clk      (clk),
        .rst      (rst),
        .cyc      (cyc),
        .bank_rom (bank_rom)
    );

    overlay_select #(.DATA_W(DATA_W)) u_sel (
        .clk        (clk),
        .rst        (rst),
        .cyc        (cyc),
        .bank_rom   (bank_rom),
        .ram_rdata  (ram_rdata),
        .rom_rdata  (rom_rdata),
        .vram_rdata (vram_rdata),
        .ram_cs     (ram_cs),
        .ram_we     (ram_we),
        .rom_cs     (rom_cs),
        .vram_cs    (vram_cs),
        .vram_we    (vram_we),
        .cpu_rdata  (cpu_rdata)
    );

endmodule

// File: tb/tb_overlay_decode_top.sv
`timescale 1ns/1ps
module tb_overlay_decode_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_m1 = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  ram_rdata, rom_rdata, vram_rdata;
    logic        ram_cs, ram_we, rom_cs, vram_cs, vram_we, bank_rom;
    logic [11:0] win_offset;
    logic [7:0]  cpu_rdata;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic [7:0] ram_mem  [256];
    logic [7:0] vram_mem [256];

    // sampled results of the last cycle
    logic [7:0] s_data;
    logic       s_ram_cs, s_ram_we, s_rom_cs, s_vram_cs, s_vram_we;
    logic [11:0] s_off;

    always #5 clk = ~clk;

    function automatic logic [7:0] rom_pat(input logic [11:0] a);
        return {a[3:0], a[7:4]} ^ 8'hC3;
    endfunction
    function automatic logic [7:0] vram_init(input int i);
        return 8'(i) ^ 8'h55;
    endfunction
    function automatic logic [7:0] ram_init(input int i);
        return 8'(i) + 8'h11;
    endfunction

    assign rom_rdata  = rom_pat(win_offset);
    assign vram_rdata = vram_mem[win_offset[7:0]];
    assign ram_rdata  = ram_mem[cpu_addr[7:0]];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) begin
                ram_mem[i]  <= ram_init(i);
                vram_mem[i] <= vram_init(i);
            end
        end else begin
            if (ram_we)  ram_mem[cpu_addr[7:0]]    <= wdata;
            if (vram_we) vram_mem[win_offset[7:0]] <= wdata;
        end
    end

    overlay_decode_top dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_m1(cpu_m1), .ram_rdata(ram_rdata), .rom_rdata(rom_rdata), .vram_rdata(vram_rdata),
        .ram_cs(ram_cs), .ram_we(ram_we), .rom_cs(rom_cs), .vram_cs(vram_cs), .vram_we(vram_we),
        .win_offset(win_offset), .cpu_rdata(cpu_rdata), .bank_rom(bank_rom)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one bus cycle: drive at negedge, sample mid-cycle, end after the edge
    task automatic bus(input logic [15:0] a, input logic rd, input logic wr,
                       input logic m1, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_m1 = m1; wdata = d;
        #2;
        s_data = cpu_rdata; s_ram_cs = ram_cs; s_ram_we = ram_we; s_rom_cs = rom_cs;
        s_vram_cs = vram_cs; s_vram_we = vram_we; s_off = win_offset;
        @(posedge clk); #1;
        cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_m1 = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
        check("R7 flag after reset", bank_rom, 1'b1);
        check("R8 idle selects", {ram_cs, rom_cs, vram_cs}, 3'b000);
        check("R8 idle rdata", cpu_rdata, 8'h00);
    endtask

    task automatic t_low_ram;
        bus(16'h0012, 0, 1, 0, 8'h5A);
        check("R1 low write ram_we", {s_ram_cs, s_ram_we, s_vram_cs, s_rom_cs}, 4'b1100);
        bus(16'h0012, 1, 0, 0, 8'h00);
        check("R1 low read back", s_data, 8'h5A);
        check("R9 flag after data cycles", bank_rom, 1'b1);
        bus(16'hEFFF, 1, 0, 0, 8'h00);
        check("R1 boundary EFFF data read", {s_ram_cs, s_data}, {1'b1, ram_init(8'hFF)});
    endtask

    task automatic t_fetch_high_low;
        logic [7:0] hi_view;
        bus(16'hF000, 1, 0, 1, 8'h00);
        check("R2 fetch F000 data", s_data, rom_pat(12'h000));
        check("R3 flag after high fetch", bank_rom, 1'b1);
        check("R10 offset", s_off, 12'h000);
        bus(16'hF000, 1, 0, 0, 8'h00);
        hi_view = s_data;
        check("R5 data read F000 flag ROM", s_data, rom_pat(12'h000));
        bus(16'h0100, 1, 0, 1, 8'h00);
        check("R4 fetch low data", s_data, ram_init(0));
        check("R4 flag after low fetch", bank_rom, 1'b0);
        bus(16'hF000, 1, 0, 0, 8'h00);
        check("R5 data read F000 flag VRAM", s_data, vram_init(0));
        check("R5 F000 differs by fetch region", (s_data != hi_view), 1'b1);
        bus(16'hEFFF, 1, 0, 1, 8'h00);
        check("R4 boundary EFFF fetch keeps VRAM", bank_rom, 1'b0);
    endtask

    task automatic t_window_writes;
        // flag is 0 here
        bus(16'hF005, 0, 1, 0, 8'h77);
        check("R6 write flag VRAM selects", {s_vram_cs, s_vram_we, s_rom_cs, s_ram_cs}, 4'b1100);
        check("R9 flag held by write", bank_rom, 1'b0);
        bus(16'hF005, 1, 0, 0, 8'h00);
        check("R6 readback via VRAM", s_data, 8'h77);
        bus(16'hF123, 1, 0, 1, 8'h00);
        check("R2 fetch serves ROM with flag VRAM", s_data, rom_pat(12'h123));
        check("R3 flag set again", bank_rom, 1'b1);
        bus(16'hF006, 0, 1, 0, 8'h99);
        check("R6 write flag ROM selects", {s_vram_cs, s_vram_we, s_rom_cs}, 3'b110);
        check("R9 flag ROM held by write", bank_rom, 1'b1);
        bus(16'hF006, 1, 0, 0, 8'h00);
        check("R5 read hides written VRAM", s_data, rom_pat(12'h006));
        bus(16'hFFFF, 1, 0, 0, 8'h00);
        check("R10 top offset", s_off, 12'hFFF);
        bus(16'h0200, 1, 0, 1, 8'h00);
        bus(16'hF006, 1, 0, 0, 8'h00);
        check("R6 write in ROM state landed in VRAM", s_data, 8'h99);
    endtask

    task automatic t_mid_reset;
        check("R7 precondition flag VRAM", bank_rom, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R7 reset mid-run", bank_rom, 1'b1);
        @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_low_ram();
        t_fetch_high_low();
        t_window_writes();
        t_mid_reset();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule